// File: doc/BRIEF.md
# Systolic Four-Tap Convolution Array

This block computes a four-tap one-dimensional convolution on a stream of signed samples. Four processing cells sit in a line, and each cell holds one stationary coefficient. Samples enter at one end and move from cell to cell through private registers. A partial sum travels beside them, and every cell adds its coefficient times the sample it sees. The finished result leaves the far end. No sample is broadcast, and no wire crosses more than one cell.

The array advances one step for each accepted sample and holds still in cycles without one, so gaps in the input stream do not change any result. Software loads coefficients through a small write port while no sample is offered. The block discards the first partial windows and raises its output strobe only for results to which all four taps have contributed.

Top module: `conv_systolic`

## Requirements
- R1: Each valid result equals y(i) = c0·x(i) + c1·x(i+1) + c2·x(i+2) + c3·x(i+3). Here x(n) is the n-th sample accepted since reset, counting from 0, and ck is the coefficient written with `loadSel` = k. Samples and coefficients are 8-bit two's complement and the result is 20-bit two's complement.
- R2: The result for window i appears on `resultOut`, with `resultValid` high, in the cycle after the clock edge that accepts sample x(i+6).
- R3: The first six accepted samples after reset produce no `resultValid`. The seventh accepted sample produces the first valid result, y(0), so the three partial windows are suppressed.
- R4: `resultValid` is high for exactly one cycle per accepted sample once the array is full, and it is never high in a cycle that follows an edge without an accepted sample.
- R5: In a cycle with `sampleValid` low, the array does not advance, and `resultOut` keeps its value through the next edge.
- R6: With `loadEn` high and `sampleValid` low, the edge writes `loadWeight` into coefficient c`loadSel`. With `sampleValid` high in the same cycle, the write is ignored.
- R7: A synchronous `rst` clears every sample and partial-sum register and the fill count, so `resultOut` reads 0 and `resultValid` reads 0. Coefficients keep their values through reset.
- R8: Idle cycles inserted anywhere in the input stream leave every result value and its window unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset of samples, sums and fill count |
| sampleValid | input | 1 | Marks `sampleIn` as an accepted sample this cycle |
| sampleIn | input | 8 | Signed input sample |
| loadEn | input | 1 | Coefficient write request, honoured only while no sample is offered |
| loadSel | input | 2 | Tap index k of the coefficient to write |
| loadWeight | input | 8 | Signed coefficient value |
| resultValid | output | 1 | One-cycle strobe marking a complete result |
| resultOut | output | 20 | Signed convolution result |

## Verification
The result for window i is due one cycle after the edge that accepts sample i+6, and `resultValid` pulses in that same cycle. In idle cycles, the strobe stays low and the value stays held. The bench drives inputs at the falling edge and checks both outputs at the next falling edge, so every check reads the state left by exactly one rising edge. A sample-history model predicts that state for every cycle. The model zero-extends the history before reset, so held values and the suppressed partial windows are checked too, not only the strobed results.

// File: rtl/conv_systolic_pkg.sv
package conv_systolic_pkg;
  localparam int TAPS     = 4;
  localparam int SAMPLE_W = 8;
  localparam int WEIGHT_W = 8;
  localparam int SUM_W    = 20;

  typedef struct packed {
    logic clear;   // synchronous clear of samples and sums
    logic step;    // advance the array by one sample
    logic load;    // write one coefficient
  } ctlStrobes_t;
endpackage

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import conv_systolic_pkg::*;
#(
  parameter int NTAPS = TAPS
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sampleValid,
  input  logic        loadEn,
  output ctlStrobes_t ctl,
  output logic        resultValid
);
  // The result register holds window i after sample i + 2*(NTAPS-1) is taken.
  localparam int FILL  = 2 * (NTAPS - 1);
  localparam int CNT_W = $clog2(FILL + 1);

  logic [CNT_W-1:0] fillCnt;
  logic             arrayFull;

  assign arrayFull = (fillCnt == CNT_W'(FILL));

  always_comb begin
    ctl.clear = rst;
    ctl.step  = sampleValid & ~rst;
    ctl.load  = loadEn & ~sampleValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt     <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= sampleValid & arrayFull;
      if (sampleValid && !arrayFull) fillCnt <= fillCnt + 1'b1;
    end
  end
endmodule

// File: rtl/conv_pe.sv
module conv_pe #(
  parameter int SAMPLE_W = 8,
  parameter int WEIGHT_W = 8,
  parameter int SUM_W    = 20
) (
  input  logic                       clk,
  input  logic                       clear,
  input  logic                       step,
  input  logic signed [WEIGHT_W-1:0] weight,
  input  logic signed [SAMPLE_W-1:0] xIn,
  input  logic signed [SUM_W-1:0]    sumIn,
  output logic signed [SAMPLE_W-1:0] xOut,
  output logic signed [SUM_W-1:0]    sumOut
);
  logic signed [SAMPLE_W-1:0] xNear, xFar;
  logic signed [SUM_W-1:0]    product, sumQ;

  // Two sample stages per cell against one sum stage: the sum overtakes
  // the samples, so each cell meets one sample older than the previous.
  assign product = SUM_W'(weight) * SUM_W'(xIn);

  always_ff @(posedge clk) begin
    if (clear) begin
      xNear <= '0;
      xFar  <= '0;
      sumQ  <= '0;
    end else if (step) begin
      xNear <= xIn;
      xFar  <= xNear;
      sumQ  <= sumIn + product;
    end
  end

  assign xOut   = xFar;
  assign sumOut = sumQ;
endmodule

// File: rtl/conv_datapath.sv
module conv_datapath
  import conv_systolic_pkg::*;
#(
  parameter int NTAPS = TAPS,
  parameter int SW    = SAMPLE_W,
  parameter int WW    = WEIGHT_W,
  parameter int RW    = SUM_W
) (
  input  logic                         clk,
  input  ctlStrobes_t                  ctl,
  input  logic [$clog2(NTAPS)-1:0]     loadSel,
  input  logic signed [WW-1:0]         loadWeight,
  input  logic signed [SW-1:0]         sampleIn,
  output logic signed [RW-1:0]         resultOut
);
  localparam int SEL_W = $clog2(NTAPS);

  logic signed [WW-1:0] weightQ [NTAPS];
  logic signed [SW-1:0] xLink   [NTAPS];
  logic signed [RW-1:0] sumLink [NTAPS+1];
  logic signed [SW-1:0] xTailUnused;

  assign xLink[0]   = sampleIn;
  assign sumLink[0] = '0;
  assign resultOut  = sumLink[NTAPS];

  for (genvar p = 0; p < NTAPS; p++) begin : g_cell
    // Cell p holds tap NTAPS-1-p: the newest sample meets the last tap first.
    always_ff @(posedge clk) begin
      if (ctl.load && loadSel == SEL_W'(NTAPS - 1 - p)) weightQ[p] <= loadWeight;
    end

    if (p < NTAPS - 1) begin : g_mid
      conv_pe #(.SAMPLE_W(SW), .WEIGHT_W(WW), .SUM_W(RW)) u_pe (
        .clk(clk), .clear(ctl.clear), .step(ctl.step), .weight(weightQ[p]),
        .xIn(xLink[p]), .sumIn(sumLink[p]),
        .xOut(xLink[p+1]), .sumOut(sumLink[p+1])
      );
    end else begin : g_last
      conv_pe #(.SAMPLE_W(SW), .WEIGHT_W(WW), .SUM_W(RW)) u_pe (
        .clk(clk), .clear(ctl.clear), .step(ctl.step), .weight(weightQ[p]),
        .xIn(xLink[p]), .sumIn(sumLink[p]),
        .xOut(xTailUnused), .sumOut(sumLink[p+1])
      );
    end
  end
endmodule

// File: rtl/conv_systolic.sv
module conv_systolic
  import conv_systolic_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sampleValid,
  input  logic signed [SAMPLE_W-1:0]   sampleIn,
  input  logic                         loadEn,
  input  logic [$clog2(TAPS)-1:0]      loadSel,
  input  logic signed [WEIGHT_W-1:0]   loadWeight,
  output logic                         resultValid,
  output logic signed [SUM_W-1:0]      resultOut
);
  ctlStrobes_t ctl;

  conv_ctrl #(.NTAPS(TAPS)) u_ctrl (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .loadEn(loadEn),
    .ctl(ctl), .resultValid(resultValid)
  );

  conv_datapath #(.NTAPS(TAPS), .SW(SAMPLE_W), .WW(WEIGHT_W), .RW(SUM_W)) u_dp (
    .clk(clk), .ctl(ctl), .loadSel(loadSel), .loadWeight(loadWeight),
    .sampleIn(sampleIn), .resultOut(resultOut)
  );
endmodule

// File: rtl/conv_checker.sv
module conv_checker
  import conv_systolic_pkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic                     sampleValid,
  input logic                     resultValid,
  input logic signed [SUM_W-1:0]  resultOut
);
  logic [3:0] acceptSeen;

  always_ff @(posedge clk) begin
    if (rst) acceptSeen <= '0;
    else if (sampleValid && acceptSeen != 4'hF) acceptSeen <= acceptSeen + 1'b1;
  end

  // R3: no strobe before the seventh accepted sample
  p_fill_before_valid_r3: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> acceptSeen >= 4'd7);

  // R4: every strobe follows an accepting edge
  p_strobe_needs_accept_r4: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> $past(sampleValid));

  // R4: an idle edge never produces a strobe
  p_idle_no_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> !resultValid);

  // R5: result holds across an idle edge
  p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> $stable(resultOut));

  // R7: leaving reset the outputs are cleared
  p_reset_clears_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (resultOut == '0 && !resultValid));
endmodule

bind conv_systolic conv_checker u_chk (
  .clk(clk), .rst(rst), .sampleValid(sampleValid),
  .resultValid(resultValid), .resultOut(resultOut)
);

// File: tb/conv_systolic_test.sv
`timescale 1ns/1ps
module conv_systolic_test;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sampleValid = 1'b0;
  logic signed [7:0] sampleIn = '0;
  logic              loadEn = 1'b0;
  logic [1:0]        loadSel = '0;
  logic signed [7:0] loadWeight = '0;
  logic              resultValid;
  logic signed [19:0] resultOut;

  conv_systolic uut (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .loadEn(loadEn), .loadSel(loadSel), .loadWeight(loadWeight),
    .resultValid(resultValid), .resultOut(resultOut)
  );

  always #2 clk = ~clk;

  int    total = 0, bad = 0;
  bit    done = 0;
  int    hist [0:255];
  int    nAcc = 0;
  int    wM [4] = '{0, 0, 0, 0};
  bit    expV = 0;
  int    expY = 0;
  string curTag = "R7";

  function automatic int windowAt(int u);
    int s = 0;
    for (int k = 0; k < 4; k++) begin
      int idx = u - 6 + k;
      if (idx >= 0) s += wM[k] * hist[idx];
    end
    return s;
  endfunction

  task automatic check(string tag);
    total++;
    if (resultValid !== expV) begin
      bad++;
      $display("FAIL %s valid: actual=%0d expected=%0d", tag, resultValid, expV);
    end
    total++;
    if (int'(resultOut) !== expY) begin
      bad++;
      $display("FAIL %s value: actual=%0d expected=%0d", tag, int'(resultOut), expY);
    end
  endtask

  // One clock: check what the previous edge produced, then drive this cycle.
  task automatic cycle(bit r, bit v, int d, bit le, int ls, int lw);
    @(negedge clk);
    check(curTag);
    rst = r; sampleValid = v; sampleIn = 8'(d);
    loadEn = le; loadSel = 2'(ls); loadWeight = 8'(lw);
    if (r) begin
      nAcc = 0; expV = 0; expY = 0;
    end else if (v) begin
      hist[nAcc] = d;
      expY = windowAt(nAcc);
      expV = (nAcc >= 6);
      nAcc++;
    end else begin
      expV = 0;
      if (le) wM[ls] = lw;
    end
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 0, 0);
  endtask

  function automatic int pat(int seed, int n);
    int tbl [9] = '{-128, 127, -1, 0, 1, 85, -86, 64, -3};
    return tbl[(seed * 7 + n * 13) % 9];
  endfunction

  initial begin
    int wv [5] = '{-128, -1, 0, 1, 127};
    int setNo = 0;
    // R7: reset state
    cycle(1, 0, 0, 0, 0, 0);
    curTag = "R7";
    idle();
    // R6: coefficient loads while idle
    curTag = "R6";
    for (int k = 0; k < 4; k++) cycle(0, 0, 0, 1, k, k + 1);
    // R1 R2 R3: impulse then ramp, back to back
    curTag = "R1_R2_R3";
    cycle(0, 1, 1, 0, 0, 0);
    for (int n = 1; n < 14; n++) cycle(0, 1, n * 3 - 20, 0, 0, 0);
    // R5: result holds during idle cycles
    curTag = "R5";
    repeat (3) idle();
    // R6: load offered together with a sample is ignored
    curTag = "R6";
    cycle(0, 1, 9, 1, 0, -50);
    for (int n = 0; n < 8; n++) cycle(0, 1, n - 4, 0, 0, 0);
    // R7: reset mid-stream keeps coefficients, refills from scratch
    curTag = "R7";
    cycle(1, 0, 0, 0, 0, 0);
    curTag = "R3_R7";
    for (int n = 0; n < 9; n++) cycle(0, 1, 100 - n * 25, 0, 0, 0);
    // R1 R4 R8: sweep of coefficient sets with extreme samples, some gapped
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 5; c++)
          for (int e = 0; e < 5; e++) begin
            cycle(1, 0, 0, 0, 0, 0);
            curTag = "R6";
            cycle(0, 0, 0, 1, 0, wv[a]);
            cycle(0, 0, 0, 1, 1, wv[b]);
            cycle(0, 0, 0, 1, 2, wv[c]);
            cycle(0, 0, 0, 1, 3, wv[e]);
            curTag = (setNo % 3 == 0) ? "R8" : "R1_R4";
            for (int n = 0; n < 10; n++) begin
              cycle(0, 1, pat(setNo, n), 0, 0, 0);
              if (setNo % 3 == 0 && n % 2 == 1) idle();
            end
            setNo++;
          end
    curTag = "R5";
    idle();
    @(negedge clk);
    check(curTag);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule